// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the device side of a paged serial flash as seen from an SPI master. It is meant for flash emulation and for verification benches that need a flash-shaped target. While chip select is low it collects an opcode and three address bytes, most significant bit first. It then takes the target page, or the first page of an eight-page block, out of the address field. Which address layout applies depends on whether the device is set up for 264-byte or 256-byte pages.

Nothing happens for a program or erase command until chip select goes high again. On that edge the block launches a self-timed operation. A parameterised countdown in system clocks models the operation, and the block raises a busy flag for exactly that long. There are four operations: program with built-in erase, program into a page that is already erased, erase one page, and erase a block of eight pages. For the combined program, an erase phase comes before the program phase. The block also answers the sector protection read. After the opcode and three dummy bytes it streams out four stored protection bytes, one per sector, and returns all ones after them.

Everything runs on the system clock. SCK, chip select and MOSI are synchronised and edge-detected, so SCK must be several times slower than the system clock.

Top module: `sflash_cmd_front`

## Requirements
- R1: Opcode 0x83 starts program-with-erase (op_kind 0), 0x88 starts program (op_kind 1), 0x81 starts page erase (op_kind 2) and 0x50 starts block erase (op_kind 3). The opcode is the first byte after chip select falls, sent MSB first.
- R2: With cfg_bin_page low, the page is bits 17:9 of the 24-bit address, which is sent MSB first. With cfg_bin_page high, the page is bits 16:8. All other address bits are ignored.
- R3: For block erase, the block number is address bits 17:12 when cfg_bin_page is low and bits 16:11 when it is high. op_page reports block number times eight.
- R4: An operation starts only after chip select rises, and only if at least 32 bits were clocked in. op_start is a single-cycle pulse.
- R5: busy is high for exactly the configured number of system clocks, counted from the op_start cycle. The counts are EP_ERASE_CYC+EP_PROG_CYC, PROG_CYC, PAGE_ERASE_CYC and BLOCK_ERASE_CYC for op_kind 0 to 3. op_kind and op_page hold steady while busy.
- R6: erase_phase is high for the first EP_ERASE_CYC busy cycles of program-with-erase and then stays low. It is high for the whole of a page or block erase and never high during a plain program.
- R7: A transaction whose chip select falls while busy is high is ignored as a whole. It starts nothing and returns all ones.
- R8: An unknown opcode starts nothing, and the serial output stays all ones until chip select rises.
- R9: After opcode 0x32 and three dummy bytes, the next 32 SCK cycles shift out prot_bytes[7:0] (sector 0), then [15:8], [23:16] and [31:24], each byte MSB first. Data changes after falling SCK edges.
- R10: After the fourth protection byte, the serial output is all ones.
- R11: spi_miso_oe is low whenever chip select is high. A new transaction always restarts the protection read from sector 0.
- R12: After reset, busy, op_start, erase_phase and spi_miso_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bin_page | input | 1 | 1 selects the 256-byte page address layout, 0 the 264-byte layout |
| prot_bytes | input | 32 | Stored protection bytes, sector 0 in bits 7:0 |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso, low means high impedance |
| busy | output | 1 | Self-timed operation in progress |
| op_start | output | 1 | One-cycle pulse when an operation is launched |
| op_kind | output | 2 | Kind of the current or last operation (R1 encoding) |
| op_page | output | 9 | Target page, or first page of the erased block |
| erase_phase | output | 1 | Current busy cycle belongs to an erase |

## Verification
A bit counter that slips by one shows up at once in two places. op_page would be a shifted copy of the page field on the very next op_start, and the protection stream would be misaligned, with the wrong byte visible within one SCK period. A countdown loaded with the wrong value appears as a busy pulse of the wrong length, measured in single system clocks when busy falls. A stuck ignore flag or a lost busy gate shows as a second op_start, or no op_start at all, within a few clocks of chip select rising.

// File: rtl/sfcf_pkg.sv
package sfcf_pkg;

  localparam int PAGE_W    = 9;
  localparam int BIT_CNT_W = 7;
  localparam int HDR_BITS  = 32;
  localparam int PROT_BITS = 32;
  localparam int ADDR_SL_W = 10;   // address bits 17:8 carry every page field

  localparam logic [7:0] OPC_PGM_ERASE   = 8'h83;
  localparam logic [7:0] OPC_PGM         = 8'h88;
  localparam logic [7:0] OPC_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OPC_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OPC_PROT_READ   = 8'h32;

  typedef enum logic [1:0] {
    OP_PGM_ERASE   = 2'd0,
    OP_PGM         = 2'd1,
    OP_PAGE_ERASE  = 2'd2,
    OP_BLOCK_ERASE = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic     valid;
    op_kind_e kind;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [7:0] opc);
    op_dec_t d;
    d.valid = 1'b1;
    d.kind  = OP_PGM_ERASE;
    case (opc)
      OPC_PGM_ERASE:   d.kind = OP_PGM_ERASE;
      OPC_PGM:         d.kind = OP_PGM;
      OPC_PAGE_ERASE:  d.kind = OP_PAGE_ERASE;
      OPC_BLOCK_ERASE: d.kind = OP_BLOCK_ERASE;
      default:         d.valid = 1'b0;
    endcase
    return d;
  endfunction

  // a holds address bits 17:8
  function automatic logic [PAGE_W-1:0] target_page(input logic [ADDR_SL_W-1:0] a,
                                                    input logic bin,
                                                    input op_kind_e k);
    logic [PAGE_W-1:0] pg;
    pg = bin ? a[8:0] : a[9:1];
    if (k == OP_BLOCK_ERASE) pg[2:0] = 3'b000;
    return pg;
  endfunction

  // k counts output bits from 0; byte k/8, MSB first
  function automatic logic prot_bit(input logic [PROT_BITS-1:0] p, input logic [4:0] k);
    return p[{k[4:3], ~k[2:0]}];
  endfunction

endpackage

// File: rtl/sfcf_pin_sync.sv
module sfcf_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_low,
  output logic cs_rise,
  output logic cs_fall,
  output logic mosi_s
);
  localparam int         NPIN    = 3;
  localparam logic [2:0] PIN_RST = 3'b100;   // {cs_n, sck, mosi}

  logic [NPIN-1:0] stg [SYNC_STAGES];
  logic [NPIN-1:0] last_q;
  logic [NPIN-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= PIN_RST;
      last_q <= PIN_RST;
    end else begin
      stg[0] <= {cs_n_i, sck_i, mosi_i};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      last_q <= stg[SYNC_STAGES-1];
    end
  end

  assign cur      = stg[SYNC_STAGES-1];
  assign mosi_s   = cur[0];
  assign sck_rise = cur[1] & ~last_q[1];
  assign sck_fall = ~cur[1] & last_q[1];
  assign cs_low   = ~cur[2];
  assign cs_rise  = cur[2] & ~last_q[2];
  assign cs_fall  = ~cur[2] & last_q[2];

endmodule

// File: rtl/sfcf_cmd_shift.sv
module sfcf_cmd_shift
  import sfcf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck_rise,
  input  logic                 sck_fall,
  input  logic                 cs_low,
  input  logic                 cs_rise,
  input  logic                 cs_fall,
  input  logic                 mosi_s,
  input  logic                 bin_mode,
  input  logic                 busy,
  input  logic [PROT_BITS-1:0] prot_bytes,
  output logic                 start_req,
  output op_kind_e             start_kind,
  output logic [PAGE_W-1:0]    start_page,
  output logic                 miso,
  output logic                 miso_oe
);
  localparam logic [BIT_CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [BIT_CNT_W-1:0] HDR_END  = BIT_CNT_W'(HDR_BITS);
  localparam logic [BIT_CNT_W-1:0] DATA_END = BIT_CNT_W'(HDR_BITS + PROT_BITS);

  logic [BIT_CNT_W-1:0] bitcnt;
  logic [HDR_BITS-1:0]  shreg;
  logic                 ignore_q;
  logic                 hdr_done;
  logic                 rd_active;
  logic                 data_bit;
  op_dec_t              dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      shreg    <= '0;
      ignore_q <= 1'b0;
    end else if (cs_fall) begin
      bitcnt   <= '0;
      ignore_q <= busy;
    end else if (sck_rise && cs_low) begin
      if (bitcnt < HDR_END) shreg <= {shreg[HDR_BITS-2:0], mosi_s};
      if (bitcnt != CNT_MAX) bitcnt <= bitcnt + 1'b1;
    end
  end

  assign hdr_done   = (bitcnt >= HDR_END);
  assign dec        = decode_op(shreg[31:24]);
  assign start_kind = dec.kind;
  assign start_page = target_page(shreg[17:8], bin_mode, dec.kind);
  assign start_req  = cs_rise && hdr_done && !ignore_q && dec.valid;

  assign rd_active = hdr_done && !ignore_q && (shreg[31:24] == OPC_PROT_READ);
  assign data_bit  = (rd_active && bitcnt < DATA_END) ? prot_bit(prot_bytes, bitcnt[4:0]) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso    <= 1'b1;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= cs_low;
      if (!cs_low)       miso <= 1'b1;
      else if (sck_fall) miso <= data_bit;
    end
  end

  AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !miso_oe); // R11

  AST_TAIL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && cs_low && bitcnt >= DATA_END) |=> miso); // R10

endmodule

// File: rtl/sfcf_busy_timer.sv
module sfcf_busy_timer
  import sfcf_pkg::*;
#(
  parameter int EP_ERASE_CYC    = 40,
  parameter int EP_PROG_CYC     = 30,
  parameter int PROG_CYC        = 30,
  parameter int PAGE_ERASE_CYC  = 40,
  parameter int BLOCK_ERASE_CYC = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  op_kind_e          start_kind,
  input  logic [PAGE_W-1:0] start_page,
  output logic              busy,
  output logic              op_start,
  output op_kind_e          op_kind,
  output logic [PAGE_W-1:0] op_page,
  output logic              erase_phase
);
  localparam int EP_TOT = EP_ERASE_CYC + EP_PROG_CYC;
  localparam int MAX_A  = (EP_TOT > PROG_CYC) ? EP_TOT : PROG_CYC;
  localparam int MAX_B  = (PAGE_ERASE_CYC > BLOCK_ERASE_CYC) ? PAGE_ERASE_CYC : BLOCK_ERASE_CYC;
  localparam int MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_D + 1);

  localparam logic [CNT_W-1:0] LD_EP    = CNT_W'(EP_TOT - 1);
  localparam logic [CNT_W-1:0] LD_PG    = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PE    = CNT_W'(PAGE_ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_BE    = CNT_W'(BLOCK_ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] PG_SPLIT = CNT_W'(EP_PROG_CYC);

  function automatic logic [CNT_W-1:0] load_val(input op_kind_e k);
    case (k)
      OP_PGM_ERASE:  return LD_EP;
      OP_PGM:        return LD_PG;
      OP_PAGE_ERASE: return LD_PE;
      default:       return LD_BE;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      busy     <= 1'b0;
      op_start <= 1'b0;
      op_kind  <= OP_PGM_ERASE;
      op_page  <= '0;
    end else begin
      op_start <= start_req;
      if (start_req) begin
        cnt     <= load_val(start_kind);
        busy    <= 1'b1;
        op_kind <= start_kind;
        op_page <= start_page;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    erase_phase = 1'b0;
    if (busy) begin
      case (op_kind)
        OP_PGM_ERASE: erase_phase = (cnt >= PG_SPLIT);
        OP_PGM:       erase_phase = 1'b0;
        default:      erase_phase = 1'b1;
      endcase
    end
  end

  AST_PHASE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_phase |-> busy); // R6

  AST_ERASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_phase) |=> !erase_phase); // R6

  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start); // R4

  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_start) |-> ($stable(op_kind) && $stable(op_page))); // R5

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> !busy); // R7

endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
  import sfcf_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int EP_ERASE_CYC    = 40,
  parameter int EP_PROG_CYC     = 30,
  parameter int PROG_CYC        = 30,
  parameter int PAGE_ERASE_CYC  = 40,
  parameter int BLOCK_ERASE_CYC = 120
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_bin_page,
  input  logic [31:0] prot_bytes,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        spi_miso_oe,
  output logic        busy,
  output logic        op_start,
  output logic [1:0]  op_kind,
  output logic [8:0]  op_page,
  output logic        erase_phase
);
  logic              sck_rise, sck_fall, cs_low, cs_rise, cs_fall, mosi_s;
  logic              start_req;
  op_kind_e          start_kind;
  logic [PAGE_W-1:0] start_page;
  op_kind_e          kind_q;

  sfcf_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_i    (spi_sck),
    .cs_n_i   (spi_cs_n),
    .mosi_i   (spi_mosi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_low   (cs_low),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall),
    .mosi_s   (mosi_s)
  );

  sfcf_cmd_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .cs_low     (cs_low),
    .cs_rise    (cs_rise),
    .cs_fall    (cs_fall),
    .mosi_s     (mosi_s),
    .bin_mode   (cfg_bin_page),
    .busy       (busy),
    .prot_bytes (prot_bytes),
    .start_req  (start_req),
    .start_kind (start_kind),
    .start_page (start_page),
    .miso       (spi_miso),
    .miso_oe    (spi_miso_oe)
  );

  sfcf_busy_timer #(
    .EP_ERASE_CYC    (EP_ERASE_CYC),
    .EP_PROG_CYC     (EP_PROG_CYC),
    .PROG_CYC        (PROG_CYC),
    .PAGE_ERASE_CYC  (PAGE_ERASE_CYC),
    .BLOCK_ERASE_CYC (BLOCK_ERASE_CYC)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .start_kind  (start_kind),
    .start_page  (start_page),
    .busy        (busy),
    .op_start    (op_start),
    .op_kind     (kind_q),
    .op_page     (op_page),
    .erase_phase (erase_phase)
  );

  assign op_kind = kind_q;

  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !$past(busy)); // R7

endmodule

// File: tb/test_sflash_cmd_front.sv
module test_sflash_cmd_front;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int T_EPE = 9, T_EPP = 7, T_PG = 5, T_PE = 6, T_BE = 600;
  localparam int NVEC = 7;
  // {opcode, address, bin layout, expected kind, expected page}
  localparam logic [43:0] VEC [NVEC] = '{
    {8'h83, 24'hFF4BFF, 1'b0, 2'd0, 9'h1A5},
    {8'h88, 24'hFEF3AA, 1'b1, 2'd1, 9'h0F3},
    {8'h81, 24'h000355, 1'b0, 2'd2, 9'h001},
    {8'h50, 24'h02DABC, 1'b0, 2'd3, 9'h168},
    {8'h50, 24'h01FFFF, 1'b1, 2'd3, 9'h1F8},
    {8'h81, 24'h03FF12, 1'b1, 2'd2, 9'h1FF},
    {8'h83, 24'h010000, 1'b1, 2'd0, 9'h100}
  };

  logic clk = 1'b0, rst_n = 1'b0, cfg_bin_page = 1'b0;
  logic [31:0] prot_bytes = 32'hC35A817E;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, busy, op_start, erase_phase;
  logic [1:0] op_kind;
  logic [8:0] op_page;

  int nchk = 0, nfail = 0;
  int starts = 0, busy_n = 0, erase_n = 0;
  logic [1:0] cap_kind;
  logic [8:0] cap_page;
  logic first_erase;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_cmd_front #(.EP_ERASE_CYC(T_EPE), .EP_PROG_CYC(T_EPP), .PROG_CYC(T_PG),
                     .PAGE_ERASE_CYC(T_PE), .BLOCK_ERASE_CYC(T_BE)) i_sflash_cmd_front (
    .clk(clk), .rst_n(rst_n), .cfg_bin_page(cfg_bin_page), .prot_bytes(prot_bytes),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .busy(busy), .op_start(op_start), .op_kind(op_kind),
    .op_page(op_page), .erase_phase(erase_phase));

  always @(negedge clk) begin
    if (op_start) begin
      starts++;
      cap_kind = op_kind;
      cap_page = op_page;
      first_erase = erase_phase;
    end
    if (busy) busy_n++;
    if (erase_phase) erase_n++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  function automatic int exp_busy(input logic [1:0] k);
    case (k)
      2'd0: return T_EPE + T_EPP;
      2'd1: return T_PG;
      2'd2: return T_PE;
      default: return T_BE;
    endcase
  endfunction

  function automatic int exp_erase(input logic [1:0] k);
    case (k)
      2'd0: return T_EPE;
      2'd1: return 0;
      2'd2: return T_PE;
      default: return T_BE;
    endcase
  endfunction

  task automatic clear_mon();
    starts = 0; busy_n = 0; erase_n = 0;
  endtask

  task automatic spi_begin();
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic spi_end();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 0; i < 8; i++) begin
      spi_mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx[7-i] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic send_hdr(input logic [7:0] opc, input logic [23:0] addr);
    logic [7:0] r;
    spi_byte(opc, r);
    spi_byte(addr[23:16], r);
    spi_byte(addr[15:8], r);
    spi_byte(addr[7:0], r);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(negedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual %0d expected 0 hung cycles", CLK_PERIOD * 20000);
    summary();
  end

  initial begin
    logic [7:0] rx;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk("R12 busy", busy, 0);
    chk("R12 op_start", op_start, 0);
    chk("R12 erase_phase", erase_phase, 0);
    chk("R12 miso_oe", spi_miso_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 oe low while cs high", spi_miso_oe, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [43:0] e;
      e = VEC[v];
      cfg_bin_page = e[11];
      clear_mon();
      spi_begin();
      send_hdr(e[43:36], e[35:12]);
      chk("R4 no start before cs rise", starts, 0);
      spi_end();
      wait_idle();
      chk("R4 one start", starts, 1);
      chk("R1 kind", cap_kind, e[10:9]);
      chk(e[10:9] == 2'd3 ? "R3 block page" : "R2 page", cap_page, e[8:0]);
      chk("R5 busy length", busy_n, exp_busy(e[10:9]));
      chk("R6 erase length", erase_n, exp_erase(e[10:9]));
      chk("R6 erase first", first_erase, (e[10:9] != 2'd1) ? 1 : 0);
    end

    // R4 short command (24 bits) starts nothing
    clear_mon();
    cfg_bin_page = 1'b0;
    spi_begin();
    spi_byte(8'h83, rx); spi_byte(8'h12, rx); spi_byte(8'h34, rx);
    spi_end();
    repeat (20) @(negedge clk);
    chk("R4 short command ignored", starts, 0);
    chk("R4 no busy after short", busy_n, 0);

    // R7 command issued while busy is ignored
    clear_mon();
    spi_begin();
    send_hdr(8'h50, 24'h001000);
    spi_end();
    chk("R7 first op started", starts, 1);
    spi_begin();
    send_hdr(8'h81, 24'h000200);
    spi_end();
    wait_idle();
    chk("R7 second command ignored", starts, 1);
    chk("R7 kind kept", cap_kind, 3);
    chk("R7 busy length untouched", busy_n, T_BE);

    // R8 unknown opcode
    clear_mon();
    spi_begin();
    send_hdr(8'hA5, 24'h000000);
    spi_byte(8'h00, rx);
    chk("R8 unknown opcode output", rx, 8'hFF);
    spi_end();
    repeat (10) @(negedge clk);
    chk("R8 unknown opcode no start", starts, 0);

    // R9 / R10 protection read
    clear_mon();
    spi_begin();
    send_hdr(8'h32, 24'h000000);
    chk("R11 oe high during read", spi_miso_oe, 1);
    spi_byte(8'h00, rx); chk("R9 sector0", rx, 8'h7E);
    spi_byte(8'h00, rx); chk("R9 sector1", rx, 8'h81);
    spi_byte(8'h00, rx); chk("R9 sector2", rx, 8'h5A);
    spi_byte(8'h00, rx); chk("R9 sector3", rx, 8'hC3);
    spi_byte(8'h00, rx); chk("R10 tail ones", rx, 8'hFF);
    spi_end();
    chk("R11 oe low after cs rise", spi_miso_oe, 0);
    chk("R9 read starts nothing", starts, 0);

    // R11 partial read restarts at sector 0
    prot_bytes = 32'h0F1E2D3C;
    spi_begin();
    send_hdr(8'h32, 24'hFFFFFF);
    spi_byte(8'h00, rx); chk("R9 first byte new data", rx, 8'h3C);
    spi_end();
    spi_begin();
    send_hdr(8'h32, 24'h000000);
    spi_byte(8'h00, rx); chk("R11 restart at sector0", rx, 8'h3C);
    spi_byte(8'h00, rx); chk("R9 sector1 after restart", rx, 8'h2D);
    spi_end();

    summary();
  end
endmodule